// File: doc/BRIEF.md
# Delay Code Programming Interface

This block holds the 8-bit code that selects one of 256 taps of a programmable delay element. Code N selects step N: the delay is the step-0 delay plus N increments, so 0x00 gives the shortest delay and 0xFF the longest. A mode pin selects how the code is loaded. In parallel mode, the code either follows an 8-bit bus while the enable is held high, or it captures the bus when the enable falls. In serial mode, a shift register is clocked by a slow serial clock while the enable is high, and the enable's falling edge commits the shift register to the active code.

The serial path can be cascaded. While new bits shift in most significant bit first, the previous contents shift out on the serial output in the same order. When the enable rises in serial mode, the shift register is reloaded from the active code. The current setting therefore reads out through the serial output, starting with bit 7 before any clock edge. This readback is destructive: whatever has been shifted in when the enable falls becomes the new code.

All external pins are sampled by a fast system clock through two-flop synchronizers. Edges of the enable and of the serial clock are detected on the sampled values. An action therefore takes effect on the third rising system-clock edge after the pin changes.

Top module: `dly_setting_if`

## Requirements
- R1: A synchronous active-high reset clears the active code to 0x00 and deasserts the serial output enable.
- R2: With mode = 1 and enable high, the active code follows the parallel bus continuously.
- R3: With mode = 1, the falling edge of enable captures the parallel bus into the active code. Later bus changes while enable is low leave the code unchanged.
- R4: With mode = 0 and enable high, each rising serial clock edge shifts serial-in into bit 0 of the shift register and moves the other bits one place toward bit 7. The first bit sent therefore ends in bit 7 (MSB first).
- R5: With mode = 0, the active code changes only on the enable's falling edge, which copies the shift register into it. Shifting leaves the code unchanged until then.
- R6: With mode = 0, the enable's rising edge loads the active code into the shift register. Serial out shows bit 7 at once, and each rising serial clock edge then presents the next lower bit.
- R7: Readback is destructive. Bits shifted in during a read replace the code when enable falls, and shifting the read data back in restores the setting.
- R8: The serial output enable is high only while mode = 0 and enable is high.
- R9: With mode = 0, the parallel bus has no effect on the active code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 1 selects parallel loading, 0 selects serial loading |
| en_i | input | 1 | Address enable: transparent level, latch strobe or serial frame |
| sclk_i | input | 1 | Serial shift clock; its rising edge is used |
| sdata_i | input | 1 | Serial data in |
| par_i | input | 8 | Parallel code bus |
| sout_o | output | 1 | Serial data out; MSB of the shift register |
| sout_oe_o | output | 1 | Serial output enable; high when sout_o should be driven |
| code_o | output | 8 | Active delay code driving the tap selector |

## Verification
The hardest case to reach from the ports is the serial readback. The old code must appear bit by bit on the serial output while a new code shifts in, and the code must stay untouched until the enable falls. To reach it, the stimulus first programs a known code by either path. It then opens a serial frame and samples the serial output before every serial clock edge, which rebuilds the previous setting MSB first. The bench checks the held code partway through the frame. A read that shifts in zeros is followed by a write-back of the read value, which exposes both the loss and the restore.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
    localparam int CODE_W      = 8;
    localparam int SYNC_STAGES = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        LOAD_SERIAL   = 1'b0,
        LOAD_PARALLEL = 1'b1
    } load_mode_e;

    typedef struct packed {
        logic  mode;
        logic  en;
        logic  sck;
        logic  sd;
        code_t par;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    typedef struct packed {
        logic  load;
        logic  shift;
        logic  sin;
        code_t load_val;
    } shift_ctl_t;

    function automatic code_t shift_in(code_t q, logic b);
        return {q[CODE_W-2:0], b};
    endfunction
endpackage

// File: rtl/dsi_sync.sv
module dsi_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dsi_edge.sv
module dsi_edge #(
    parameter int W        = 2,
    parameter int FALL_IDX = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] rise_o,
    output logic         fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= d_i;
    end

    for (genvar b = 0; b < W; b++) begin : g_rise
        assign rise_o[b] = d_i[b] & ~prev_q[b];
    end

    assign fall_o = ~d_i[FALL_IDX] & prev_q[FALL_IDX];
endmodule

// File: rtl/dsi_shift.sv
module dsi_shift
    import dsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  shift_ctl_t ctl_i,
    output code_t      q_o
);
    code_t q;

    always_ff @(posedge clk) begin
        if (rst)              q <= '0;
        else if (ctl_i.load)  q <= ctl_i.load_val;
        else if (ctl_i.shift) q <= shift_in(q, ctl_i.sin);
    end

    assign q_o = q;
endmodule

// File: rtl/dsi_code.sv
module dsi_code
    import dsi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  upd_i,
    input  code_t val_i,
    output code_t q_o
);
    code_t q;

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (upd_i) q <= val_i;
    end

    assign q_o = q;
endmodule

// File: rtl/dly_setting_if.sv
module dly_setting_if
    import dsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_i,
    input  logic              en_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic [CODE_W-1:0] par_i,
    output logic              sout_o,
    output logic              sout_oe_o,
    output logic [CODE_W-1:0] code_o
);
    pins_t            pins_raw;
    pins_t            pins_s;
    logic [PIN_W-1:0] pins_vec;
    logic [1:0]       rise;
    logic             en_rise;
    logic             en_fall;
    logic             sck_rise;
    logic             is_serial;
    shift_ctl_t       sh_ctl;
    code_t            sh_q;
    code_t            code_q;
    logic             code_upd;
    code_t            code_val;

    assign pins_raw = {mode_i, en_i, sclk_i, sdata_i, par_i};

    dsi_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_raw),
        .q_o (pins_vec)
    );

    assign pins_s = pins_t'(pins_vec);

    dsi_edge #(.W(2), .FALL_IDX(1)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .d_i    ({pins_s.en, pins_s.sck}),
        .rise_o (rise),
        .fall_o (en_fall)
    );

    assign en_rise   = rise[1];
    assign sck_rise  = rise[0];
    assign is_serial = (load_mode_e'(pins_s.mode) == LOAD_SERIAL);

    always_comb begin
        sh_ctl.load     = is_serial && en_rise;
        sh_ctl.shift    = is_serial && pins_s.en && sck_rise;
        sh_ctl.sin      = pins_s.sd;
        sh_ctl.load_val = code_q;
    end

    dsi_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .ctl_i (sh_ctl),
        .q_o   (sh_q)
    );

    always_comb begin
        if (is_serial) begin
            code_upd = en_fall;
            code_val = sh_q;
        end else begin
            code_upd = pins_s.en || en_fall;
            code_val = pins_s.par;
        end
    end

    dsi_code u_code (
        .clk   (clk),
        .rst   (rst),
        .upd_i (code_upd),
        .val_i (code_val),
        .q_o   (code_q)
    );

    assign code_o    = code_q;
    assign sout_o    = sh_q[CODE_W-1];
    assign sout_oe_o = is_serial && pins_s.en;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (code_o == '0 && !sout_oe_o));

    assert_transparent_R2: assert property (@(posedge clk) disable iff (rst)
        (!is_serial && pins_s.en) |=> (code_o == $past(pins_s.par)));

    assert_latch_R3: assert property (@(posedge clk) disable iff (rst)
        (!is_serial && en_fall) |=> (code_o == $past(pins_s.par)));

    assert_shift_order_R4: assert property (@(posedge clk) disable iff (rst)
        (is_serial && pins_s.en && sck_rise && !en_rise) |=>
        (sh_q == {$past(sh_q[CODE_W-2:0]), $past(pins_s.sd)}));

    assert_serial_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (is_serial && !en_fall) |=> $stable(code_o));

    assert_readback_load_R6: assert property (@(posedge clk) disable iff (rst)
        (is_serial && en_rise) |=> (sh_q == $past(code_o)));
endmodule

// File: tb/tb_dly_setting_if.sv
`timescale 1ns/1ps
module tb_dly_setting_if;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_i = 1'b1;
    logic       en_i = 1'b0;
    logic       sclk_i = 1'b0;
    logic       sdata_i = 1'b0;
    logic [7:0] par_i = 8'h00;
    logic       sout_o;
    logic       sout_oe_o;
    logic [7:0] code_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dly_setting_if dut (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_i),
        .en_i      (en_i),
        .sclk_i    (sclk_i),
        .sdata_i   (sdata_i),
        .par_i     (par_i),
        .sout_o    (sout_o),
        .sout_oe_o (sout_oe_o),
        .code_o    (code_o)
    );

    // kind: 0 transparent, 1 latched, 2 serial; low byte is the code
    localparam logic [9:0] VEC [8] = '{
        {2'd0, 8'h5A}, {2'd1, 8'hC3}, {2'd2, 8'h96}, {2'd2, 8'h01},
        {2'd0, 8'hFF}, {2'd2, 8'h80}, {2'd1, 8'h00}, {2'd2, 8'h7E}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic par_transparent(input logic [7:0] v);
        mode_i = 1'b1; en_i = 1'b1; par_i = v;
        tick(5);
    endtask

    task automatic par_latch(input logic [7:0] v);
        mode_i = 1'b1; en_i = 1'b1; par_i = v;
        tick(5);
        en_i = 1'b0;
        tick(5);
        par_i = ~v;
        tick(5);
        chk("R3 bus change after latch ignored", code_o, v);
    endtask

    task automatic ser_xfer(input logic [7:0] v, output logic [7:0] old);
        logic [7:0] held;
        en_i = 1'b0;
        tick(5);
        mode_i = 1'b0;
        tick(5);
        held = code_o;
        en_i = 1'b1;
        tick(5);
        for (int i = 7; i >= 0; i--) begin
            old[i]  = sout_o;
            sdata_i = v[i];
            tick(2);
            sclk_i = 1'b1;
            tick(5);
            sclk_i = 1'b0;
            tick(5);
            if (i == 4) chk("R5 code held mid-frame", code_o, held);
        end
        chk("R5 code held before enable falls", code_o, held);
        en_i = 1'b0;
        tick(5);
    endtask

    initial begin
        logic [7:0] old;
        logic [7:0] prev;
        tick(4);
        chk("R1 reset code", code_o, 8'h00);
        chk("R1 reset oe", {7'd0, sout_oe_o}, 8'h00);
        rst = 1'b0;
        tick(2);
        prev = 8'h00;

        for (int k = 0; k < 8; k++) begin
            case (VEC[k][9:8])
                2'd0: begin
                    par_transparent(VEC[k][7:0]);
                    chk("R2 transparent", code_o, VEC[k][7:0]);
                end
                2'd1: begin
                    par_latch(VEC[k][7:0]);
                    chk("R3 latched", code_o, VEC[k][7:0]);
                end
                default: begin
                    ser_xfer(VEC[k][7:0], old);
                    chk("R4 serial write", code_o, VEC[k][7:0]);
                    chk("R6 readback of previous code", old, prev);
                end
            endcase
            prev = VEC[k][7:0];
        end

        // transparent follows several bus values without an enable pulse
        par_transparent(8'h11);
        par_i = 8'h22; tick(5);
        chk("R2 follows second value", code_o, 8'h22);
        par_i = 8'hE7; tick(5);
        chk("R2 follows third value", code_o, 8'hE7);

        // output enable
        chk("R8 oe low in parallel mode", {7'd0, sout_oe_o}, 8'h00);
        en_i = 1'b0; tick(5);
        mode_i = 1'b0; tick(5);
        chk("R8 oe low with enable low", {7'd0, sout_oe_o}, 8'h00);
        // parallel bus ignored in serial mode, enable low
        par_i = 8'h3C; tick(5);
        chk("R9 bus ignored, enable low", code_o, 8'hE7);
        en_i = 1'b1; tick(5);
        chk("R8 oe high in serial frame", {7'd0, sout_oe_o}, 8'h01);
        chk("R6 bit 7 before any clock", {7'd0, sout_o}, 8'h01);
        par_i = 8'hC5; tick(5);
        chk("R9 bus ignored, enable high", code_o, 8'hE7);
        en_i = 1'b0; tick(5);
        chk("R9 empty frame commits unchanged code", code_o, 8'hE7);

        // destructive readback and restore
        ser_xfer(8'h00, old);
        chk("R7 read value", old, 8'hE7);
        chk("R7 setting lost", code_o, 8'h00);
        ser_xfer(old, prev);
        chk("R7 read after loss", prev, 8'h00);
        chk("R7 setting restored", code_o, 8'hE7);

        // two frames in a row shift the same data around
        ser_xfer(8'hA5, old);
        ser_xfer(8'h5A, prev);
        chk("R4 MSB-first chain output", prev, 8'hA5);
        chk("R4 second frame code", code_o, 8'h5A);

        // reset mid-operation
        mode_i = 1'b0; en_i = 1'b1; tick(5);
        rst = 1'b1; tick(3);
        chk("R1 reset mid-operation code", code_o, 8'h00);
        chk("R1 reset mid-operation oe", {7'd0, sout_oe_o}, 8'h00);
        rst = 1'b0; en_i = 1'b0; tick(5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule